// File: doc/BRIEF.md
# Page program collector with in-page wrap

This block sits behind the serial front end of a small flash-style memory model and handles the data phase of a page-program command. A start pulse carries the 24-bit target address. Its low eight bits set the first write offset inside a 256-byte page, and the bits above them select the page. Each complete data byte that follows is placed at the current offset, and the offset then steps forward. Past offset 255 it wraps back to offset 0 of the same page. A later byte therefore replaces an earlier one at the same offset, so when more than a page of data arrives only the most recent 256 bytes remain.

When chip select rises, the collected bytes are committed to a small internal array model in one cycle. Only offsets that received a byte are written. Each written byte is ANDed with the old contents, so a program operation can only clear bits. A busy flag then stays high for a program time that grows linearly with the number of bytes committed. A byte strobe that the front end flags as incomplete is dropped. A command that ends with no whole byte programs nothing.

Top module: `pp_page_program`

## Requirements
- R1: After reset, busy_o and commit_o are low and every array byte reads 8'hFF.
- R2: The first accepted data byte is written at offset addr_i[7:0] of page (addr_i[23:8] mod PAGES), and each following byte goes to the next offset.
- R3: A byte that would go past offset 255 is written at offset 0 of the same page. No other page changes.
- R4: When more than 256 whole bytes arrive, each offset holds the last byte received for it, so only the final 256 bytes are programmed.
- R5: A byte strobe is a whole byte only when bit_cnt_i is 0. A strobe with bit_cnt_i in 1..7 carries a partial trailing byte and changes neither the array nor the mask.
- R6: Committing a byte stores old AND new at that offset, so a bit cleared before stays cleared. Offsets that received no byte keep their old value.
- R7: commit_o is a one-cycle pulse in the cycle after the cycle in which cs_rise_i is sampled. During that pulse, bit i of commit_mask_o is 1 exactly when offset i received a whole byte.
- R8: busy_o rises in the cycle after the commit pulse and stays high for exactly T_BASE + T_BYTE*N cycles, where N = min(whole bytes received, 256).
- R9: A cs_rise_i that follows a start with no whole byte causes no commit pulse and no busy period.
- R10: While busy_o or commit_o is high, start_i and byte strobes are ignored. A byte strobe or cs_rise_i with no command in progress also has no effect.
- R11: Each new command clears the mask, so bytes of an earlier command are never committed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Page-program command start pulse |
| addr_i | input | 24 | Target address; bits 7:0 give the start offset, bits 23:8 the page |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| bit_cnt_i | input | 3 | Bits in the strobed byte; 0 means a whole byte, 1..7 a partial one |
| cs_rise_i | input | 1 | Chip-select rising event that ends the command |
| rd_addr_i | input | $clog2(PAGES)+8 | Array read address (page, offset) |
| commit_o | output | 1 | One-cycle commit request |
| commit_mask_o | output | 256 | Per-offset enable of the commit |
| busy_o | output | 1 | Program time in progress |
| rd_data_o | output | 8 | Array byte at rd_addr_i |

## Verification
The bench starts commands near the page end, so that a design that crosses into the next page or drops the wrapped bytes leaves the wrong page contents. It sends 300 bytes: keeping the first byte instead of the last at a reused offset, or letting the count run past 256, shows up in the array and in the busy length. It ends a command on a zeroing partial byte, programs one offset twice and starts a second command after a first, which catches AND-less writes, kept partial bytes and a stale mask. It also issues a start and bytes during busy, a lone byte and a bare chip-select rise, none of which may produce a commit.

// File: rtl/pp_pkg.sv
package pp_pkg;
    localparam int ADDR_W     = 24;
    localparam int OFF_W      = 8;
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int PG_W       = ADDR_W - OFF_W;
    localparam int CNT_W      = OFF_W + 1;

    typedef enum logic [0:0] {
        PP_IDLE = 1'b0,
        PP_FILL = 1'b1
    } pp_state_e;
endpackage

// File: rtl/pp_collect.sv
module pp_collect
    import pp_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic                           byte_vld_i,
    input  logic [7:0]                     byte_i,
    input  logic [2:0]                     bit_cnt_i,
    input  logic                           cs_rise_i,
    input  logic                           hold_i,
    output logic                           launch_o,
    output logic [PG_W-1:0]                page_o,
    output logic [CNT_W-1:0]               count_o,
    output logic [PAGE_BYTES-1:0]          mask_o,
    output logic [PAGE_BYTES-1:0][7:0]     data_o
);
    typedef struct packed {
        pp_state_e                     st;
        logic                          launch;
        logic [OFF_W-1:0]              off;
        logic [PG_W-1:0]               page;
        logic [CNT_W-1:0]              cnt;
        logic [PAGE_BYTES-1:0]         mask;
        logic [PAGE_BYTES-1:0][7:0]    data;
    } coll_t;

    coll_t q, d;
    logic  whole_byte;

    assign whole_byte = byte_vld_i && (bit_cnt_i == 3'd0);

    always_comb begin
        d        = q;
        d.launch = 1'b0;
        if (start_i && !hold_i) begin
            // new command: restart collection, forget earlier bytes
            d.st   = PP_FILL;
            d.off  = addr_i[OFF_W-1:0];
            d.page = addr_i[ADDR_W-1:OFF_W];
            d.cnt  = '0;
            d.mask = '0;
        end else if (q.st == PP_FILL) begin
            if (whole_byte) begin
                d.data[q.off] = byte_i;
                d.mask[q.off] = 1'b1;
                d.off         = q.off + 1'b1;   // wraps inside the page
                if (q.cnt != CNT_W'(PAGE_BYTES))
                    d.cnt = q.cnt + 1'b1;
            end
            if (cs_rise_i) begin
                d.st     = PP_IDLE;
                d.launch = (d.cnt != '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign launch_o = q.launch;
    assign page_o   = q.page;
    assign count_o  = q.cnt;
    assign mask_o   = q.mask;
    assign data_o   = q.data;
endmodule

// File: rtl/pp_timer.sv
module pp_timer
    import pp_pkg::*;
#(
    parameter int T_BASE = 20,
    parameter int T_BYTE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             busy_o
);
    localparam int T_MAX = T_BASE + T_BYTE * PAGE_BYTES;
    localparam int TW    = $clog2(T_MAX + 1);

    typedef struct packed {
        logic [TW-1:0] left;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (load_i)
            d.left = TW'(T_BASE) + TW'(T_BYTE) * TW'(count_i);
        else if (q.left != '0)
            d.left = q.left - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = (q.left != '0);
endmodule

// File: rtl/pp_array.sv
module pp_array
    import pp_pkg::*;
#(
    parameter int PAGES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_i,
    input  logic [PG_W-1:0]             page_i,
    input  logic [PAGE_BYTES-1:0]       mask_i,
    input  logic [PAGE_BYTES-1:0][7:0]  data_i,
    input  logic [$clog2(PAGES)+OFF_W-1:0] rd_addr_i,
    output logic [7:0]                  rd_data_o
);
    localparam int PB    = $clog2(PAGES);
    localparam int DEPTH = PAGES * PAGE_BYTES;

    logic [7:0]    mem [DEPTH];
    logic [PB-1:0] pidx;

    assign pidx = PB'(page_i % PG_W'(PAGES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_i) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (mask_i[i])
                    mem[{pidx, OFF_W'(i)}] <= mem[{pidx, OFF_W'(i)}] & data_i[i];
        end
    end

    assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/pp_page_program.sv
module pp_page_program
    import pp_pkg::*;
#(
    parameter int PAGES  = 4,
    parameter int T_BASE = 20,
    parameter int T_BYTE = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start_i,
    input  logic [23:0]                     addr_i,
    input  logic                            byte_vld_i,
    input  logic [7:0]                      byte_i,
    input  logic [2:0]                      bit_cnt_i,
    input  logic                            cs_rise_i,
    input  logic [$clog2(PAGES)+7:0]        rd_addr_i,
    output logic                            commit_o,
    output logic [255:0]                    commit_mask_o,
    output logic                            busy_o,
    output logic [7:0]                      rd_data_o
);
    logic                          launch;
    logic [PG_W-1:0]               page;
    logic [CNT_W-1:0]              count;
    logic [PAGE_BYTES-1:0]         mask;
    logic [PAGE_BYTES-1:0][7:0]    data;
    logic                          busy;

    pp_collect u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .addr_i     (addr_i),
        .byte_vld_i (byte_vld_i),
        .byte_i     (byte_i),
        .bit_cnt_i  (bit_cnt_i),
        .cs_rise_i  (cs_rise_i),
        .hold_i     (busy | launch),
        .launch_o   (launch),
        .page_o     (page),
        .count_o    (count),
        .mask_o     (mask),
        .data_o     (data)
    );

    pp_timer #(.T_BASE(T_BASE), .T_BYTE(T_BYTE)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (launch),
        .count_i (count),
        .busy_o  (busy)
    );

    pp_array #(.PAGES(PAGES)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (launch),
        .page_i    (page),
        .mask_i    (mask),
        .data_i    (data),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

    assign commit_o      = launch;
    assign commit_mask_o = mask;
    assign busy_o        = busy;
endmodule

// File: rtl/pp_checker.sv
module pp_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         commit_o,
    input logic [255:0] commit_mask_o,
    input logic         busy_o
);
    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);                                   // R7
    AST_BUSY_FOLLOWS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> busy_o);                                      // R8
    AST_BUSY_RISE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(commit_o));                        // R8
    AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (commit_mask_o != '0));                       // R9
    AST_NO_COMMIT_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !commit_o);                                     // R10
endmodule

bind pp_page_program pp_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .commit_o      (commit_o),
    .commit_mask_o (commit_mask_o),
    .busy_o        (busy_o)
);

// File: tb/sim_pp_page_program.sv
module sim_pp_page_program;
    localparam int PAGES  = 4;
    localparam int T_BASE = 20;
    localparam int T_BYTE = 2;
    localparam int DEPTH  = PAGES * 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] addr_i = '0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic [2:0]  bit_cnt_i = '0;
    logic        cs_rise_i = 1'b0;
    logic [9:0]  rd_addr_i = '0;
    logic        commit_o;
    logic [255:0] commit_mask_o;
    logic        busy_o;
    logic [7:0]  rd_data_o;

    int checks = 0;
    int fails  = 0;

    logic [7:0]   exp_mem [DEPTH];
    logic [7:0]   stim [512];
    logic [7:0]   exp_buf [256];
    logic [255:0] exp_mask;

    always #5 clk = ~clk;

    pp_page_program #(.PAGES(PAGES), .T_BASE(T_BASE), .T_BYTE(T_BYTE)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .bit_cnt_i(bit_cnt_i),
        .cs_rise_i(cs_rise_i), .rd_addr_i(rd_addr_i), .commit_o(commit_o),
        .commit_mask_o(commit_mask_o), .busy_o(busy_o), .rd_data_o(rd_data_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int popc(input logic [255:0] m);
        int c = 0;
        for (int i = 0; i < 256; i++) c += int'(m[i]);
        return c;
    endfunction

    task automatic check_array(input string req);
        int bad = -1;
        logic [7:0] got = '0;
        for (int i = 0; i < DEPTH; i++) begin
            rd_addr_i = 10'(i);
            #0.1;
            if (rd_data_o !== exp_mem[i] && bad < 0) begin
                bad = i;
                got = rd_data_o;
            end
        end
        if (bad < 0) chk(1'b1, req, "array", 0, 0);
        else chk(1'b0, req, $sformatf("array byte %0d", bad), 256'(got), 256'(exp_mem[bad]));
    endtask

    // one command: start, n whole bytes from stim, optional partial, chip-select rise
    task automatic run_cmd(input logic [23:0] a, input int n, input bit partial,
                           input bit poke, input string req);
        logic [7:0] off;
        int pg, t_exp, cnt;
        exp_mask = '0;
        off = a[7:0];
        for (int k = 0; k < n; k++) begin
            exp_buf[off]  = stim[k];
            exp_mask[off] = 1'b1;
            off = off + 8'd1;
        end
        @(negedge clk); start_i = 1'b1; addr_i = a;
        @(negedge clk); start_i = 1'b0;
        for (int k = 0; k < n; k++) begin
            byte_vld_i = 1'b1; byte_i = stim[k]; bit_cnt_i = 3'd0;
            @(negedge clk);
        end
        byte_vld_i = 1'b0;
        if (partial) begin
            byte_vld_i = 1'b1; byte_i = 8'h00; bit_cnt_i = 3'd3;
            @(negedge clk);
            byte_vld_i = 1'b0; bit_cnt_i = 3'd0;
        end
        cs_rise_i = 1'b1;
        @(negedge clk); cs_rise_i = 1'b0;
        if (n == 0) begin
            for (int c = 0; c < 3; c++) begin
                chk(commit_o == 1'b0 && busy_o == 1'b0, "R9", "empty command idle",
                    256'({commit_o, busy_o}), 0);
                @(negedge clk);
            end
            check_array("R9");
            return;
        end
        chk(commit_o == 1'b1, "R7", "commit pulse", 256'(commit_o), 1);
        chk(commit_mask_o == exp_mask, "R11", "commit mask", commit_mask_o, exp_mask);
        t_exp = T_BASE + T_BYTE * popc(exp_mask);
        cnt = 0;
        forever begin
            @(negedge clk);
            if (!busy_o || cnt > 5000) break;
            if (cnt == 0) chk(commit_o == 1'b0, "R7", "pulse width", 256'(commit_o), 0);
            cnt++;
            if (poke && cnt == 3) begin
                start_i = 1'b1; addr_i = 24'h000000; byte_vld_i = 1'b1; byte_i = 8'h00;
            end else begin
                start_i = 1'b0; byte_vld_i = 1'b0;
            end
        end
        start_i = 1'b0; byte_vld_i = 1'b0;
        chk(cnt == t_exp, "R8", "busy length", 256'(cnt), 256'(t_exp));
        pg = int'(a[23:8]) % PAGES;
        for (int i = 0; i < 256; i++)
            if (exp_mask[i]) exp_mem[pg*256+i] = exp_mem[pg*256+i] & exp_buf[i];
        check_array(req);
    endtask

    // stray byte and bare chip-select rise with no command open
    task automatic idle_noise(input string req);
        @(negedge clk); byte_vld_i = 1'b1; byte_i = 8'h00; bit_cnt_i = 3'd0;
        @(negedge clk); byte_vld_i = 1'b0; cs_rise_i = 1'b1;
        @(negedge clk); cs_rise_i = 1'b0;
        for (int c = 0; c < 3; c++) begin
            chk(commit_o == 1'b0 && busy_o == 1'b0, req, "no commit when idle",
                256'({commit_o, busy_o}), 0);
            @(negedge clk);
        end
        check_array(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy_o == 1'b0, "R1", "busy at reset", 256'(busy_o), 0);
        chk(commit_o == 1'b0, "R1", "commit at reset", 256'(commit_o), 0);
        check_array("R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: start offset and page select
        stim[0] = 8'hA5; stim[1] = 8'h5A; stim[2] = 8'h0F;
        run_cmd(24'h000105, 3, 1'b0, 1'b0, "R2");

        // R3: wrap from offset 254 back to 0 of the same page
        for (int k = 0; k < 5; k++) stim[k] = 8'h11 * 8'(k + 1);
        run_cmd(24'h0002FE, 5, 1'b0, 1'b0, "R3");

        // R4: 300 bytes, last 256 win
        for (int k = 0; k < 300; k++) stim[k] = 8'($urandom);
        run_cmd(24'h000310, 300, 1'b0, 1'b0, "R4");

        // R5: trailing partial byte (bit count 3, data zero) is dropped
        stim[0] = 8'hC3; stim[1] = 8'h7E;
        run_cmd(24'h000020, 2, 1'b1, 1'b0, "R5");

        // R6: second program of one offset ANDs with old contents
        stim[0] = 8'hF0;
        run_cmd(24'h000040, 1, 1'b0, 1'b0, "R6");
        stim[0] = 8'h3C;
        run_cmd(24'h000040, 1, 1'b0, 1'b0, "R6");
        rd_addr_i = 10'h040; #0.1;
        chk(rd_data_o == 8'h30, "R6", "AND result", 256'(rd_data_o), 256'(8'h30));

        // R9: only a partial byte, then chip-select rise
        run_cmd(24'h000180, 0, 1'b1, 1'b0, "R9");

        // R10: start and byte during busy, then stray traffic while idle
        stim[0] = 8'h96; stim[1] = 8'h69; stim[2] = 8'hE7; stim[3] = 8'h7E;
        run_cmd(24'h000250, 4, 1'b0, 1'b1, "R10");
        idle_noise("R10");

        // R11: second command's mask holds only its own offsets
        for (int k = 0; k < 8; k++) stim[k] = 8'hF7;
        run_cmd(24'h000180, 8, 1'b0, 1'b0, "R11");
        stim[0] = 8'hBF; stim[1] = 8'hFD;
        run_cmd(24'h000190, 2, 1'b0, 1'b0, "R11");

        // constrained random commands
        for (int r = 0; r < 30; r++) begin
            int n;
            logic [23:0] a;
            a = 24'($urandom);
            n = int'($urandom_range(1, 300));
            if (r % 5 == 0) a[7:0] = 8'hF0 + 8'($urandom_range(0, 15));
            for (int k = 0; k < n; k++) stim[k] = 8'($urandom | $urandom);
            run_cmd(a, n, 1'($urandom_range(0, 1)), 1'b0, "R4");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule